// File: doc/BRIEF.md
# I2C Message Transaction Sequencer

This block runs one complete I2C message without software involvement. It sits on top of a status-code style I2C master: the master posts an 8-bit status code each time a bus phase finishes. For each posted code, the sequencer decides what happens next. It then writes the master's transmit-data register and control register through write strobes. The host first loads the outgoing bytes into a local byte buffer. It then pulses `go` with a target address, an address-width flag, a direction, a byte count and a no-start option. At the end it collects the received bytes from the same buffer. Completion is a single-cycle `done` pulse with a 2-bit result code.

The next action is chosen from the status code alone. Only three pieces of context also affect the choice:
- whether the message uses 10-bit addressing;
- how many bytes are left;
- whether an abort is pending.

The controller states are SQ_IDLE, SQ_WAIT_START, SQ_WAIT_ADDR1, SQ_WAIT_ADDR2, SQ_WAIT_TXACK and SQ_WAIT_RXDATA. The transitions are:
- SQ_IDLE→SQ_WAIT_START on `go`. With the no-start option, a read goes to SQ_WAIT_RXDATA and a write goes to SQ_WAIT_TXACK instead.
- Any busy state→SQ_WAIT_ADDR1 on status 0x08 or 0x10.
- →SQ_WAIT_ADDR2 on 0x18 or 0x40 in 10-bit mode.
- →SQ_WAIT_TXACK on a write acknowledge (0x18, 0x28, 0xD0) while bytes remain.
- →SQ_WAIT_RXDATA on 0x40, 0xE0 or 0x50 with bytes still to read.
- Any state→SQ_IDLE whenever a STOP is written.

Every write the sequencer makes appears on its outputs one clock after the status code or `go` that caused it.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: In 7-bit mode, on status 0x08 or 0x10 the sequencer writes the data byte {addr[6:0], dir}, where dir is 1 for a read. It writes it together with a control value of 0xC4.
- R2: In 10-bit mode the first address byte is 0xF0 | (addr[9:8] << 1) | dir. On status 0x18 (write) or 0x40 (read), the second address byte addr[7:0] is then written.
- R3: The control byte layout is bit 7 interrupt enable, bit 6 module enable, bit 5 START, bit 4 STOP, bit 3 interrupt flag (always written as 0) and bit 2 ACK. On `go` in idle without the no-start option, the sequencer writes control 0xE4 and no data. A `go` while a message is in progress has no effect.
- R4: On write acknowledges (0x18 in 7-bit mode, 0xD0, 0x28), buffer bytes are sent in index order from 0, each with control 0xC4. Once no bytes remain, the next acknowledge writes a STOP and the message ends with result 0 (ok).
- R5: On read address acknowledge (0x40 in 7-bit mode, or 0xE0), reception continues with a control write and no data write. Each 0x50 stores the received byte at the next buffer index. ACK (bit 2) is cleared as soon as one byte remains, and stays cleared.
- R6: Status 0x58 stores the final received byte, writes control 0x50 and ends the message with result 0.
- R7: A message with a byte count of 0 writes a STOP on the first address acknowledge (0x18, 0x40, 0xD0 or 0xE0) and ends with result 0.
- R8: Every STOP write has control bits [7:4] equal to 0101. Every message end pulses `done` for exactly one cycle with a STOP write. Statuses 0x20, 0x30 and 0x48 end the message with result 1 (no device).
- R9: Any status not listed in R1 to R8 ends a busy message with a STOP and result 2 (controller error).
- R10: An `abort` pulse during a message is remembered. A write stops at the next acknowledge once at least one byte has been sent, with result 3 if bytes were left. A read clears ACK on its next control write and ends with result 3 on 0x58 if bytes were left. An abort in idle is ignored.
- R11: With the no-start option, the START and address phases are skipped. A write sends buffer byte 0 with control 0xC4 at once; with a count of 0 it stops at once with result 0. A read only writes control 0xC4, or 0xC0 if the count is 1.
- R12: A status posted while idle produces a STOP write and no `done` pulse. The sequencer stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start one message (taken only when idle) |
| tgt_addr | input | 10 | Target address (bits 6:0 used in 7-bit mode) |
| ten_bit | input | 1 | 10-bit addressing |
| rd_dir | input | 1 | 1 = read, 0 = write |
| no_start | input | 1 | Skip START and address phases |
| byte_cnt | input | LEN_W | Number of data bytes |
| abort | input | 1 | Request early termination |
| buf_we | input | 1 | Host write into the byte buffer |
| buf_idx | input | IDX_W | Host buffer index (write and read) |
| buf_wdata | input | 8 | Host write data |
| buf_rdata | output | 8 | Buffer content at buf_idx |
| stat_vld | input | 1 | Master posts a status code this cycle |
| stat_code | input | 8 | Posted status code |
| rx_byte | input | 8 | Master's received-data register |
| data_we | output | 1 | Write strobe for the master's data register |
| data_wd | output | 8 | Data register write value |
| ctrl_we | output | 1 | Write strobe for the master's control register |
| ctrl_wd | output | 8 | Control register write value |
| done | output | 1 | One-cycle message completion pulse |
| result | output | 2 | 0 ok, 1 no device, 2 controller error, 3 aborted |

## Verification
The bench targets the corner cases at the boundaries of the byte count. A count of zero must stop right after the address. Without that check, a design would send a stale buffer byte or wait for data that never comes. A count of one must clear ACK before the only byte is received. Otherwise the last byte is acknowledged and the target keeps driving the bus.

Each 10-bit direction is checked for its second address byte. The same status codes 0x18 and 0x40 mean "send data" or "start reading" in 7-bit mode, so a design that confused the two cases would skip the second address.

Aborts are placed both before and after the first byte. A design that stopped at once would send nothing, and one that ignored the abort would run the full count. Each error status is checked for its own result code. A `go` issued mid-message is checked to show that it leaves the address in flight unchanged.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT_START,
        SQ_WAIT_ADDR1,
        SQ_WAIT_ADDR2,
        SQ_WAIT_TXACK,
        SQ_WAIT_RXDATA
    } sq_state_e;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_NODEV  = 2'd1,
        RES_CTLERR = 2'd2,
        RES_ABORT  = 2'd3
    } sq_result_e;

    // Control register bit positions decoded by the I2C master
    localparam int CB_ACK   = 2;
    localparam int CB_STOP  = 4;
    localparam int CB_START = 5;
    localparam int CB_IE    = 7;

    // Status codes posted by the master
    localparam logic [7:0] ST_START    = 8'h08;
    localparam logic [7:0] ST_RESTART  = 8'h10;
    localparam logic [7:0] ST_WA_ACK   = 8'h18;
    localparam logic [7:0] ST_WA_NAK   = 8'h20;
    localparam logic [7:0] ST_WD_ACK   = 8'h28;
    localparam logic [7:0] ST_WD_NAK   = 8'h30;
    localparam logic [7:0] ST_RA_ACK   = 8'h40;
    localparam logic [7:0] ST_RA_NAK   = 8'h48;
    localparam logic [7:0] ST_RD_ACK   = 8'h50;
    localparam logic [7:0] ST_RD_NAK   = 8'h58;
    localparam logic [7:0] ST_WA2_ACK  = 8'hD0;
    localparam logic [7:0] ST_RA2_ACK  = 8'hE0;

    // Control byte: ie, enable(1), start, stop, flag(0), ack, 2'b00
    function automatic logic [7:0] ctl_byte(input logic ie, input logic start,
                                            input logic stop, input logic ack);
        return {ie, 1'b1, start, stop, 1'b0, ack, 2'b00};
    endfunction

endpackage

// File: rtl/i2cseq_addr_fmt.sv
module i2cseq_addr_fmt (
    input  logic [9:0] addr,
    input  logic       ten,
    input  logic       rd,
    output logic [7:0] first_b,
    output logic [7:0] second_b
);
    always_comb begin
        if (ten) first_b = {5'b11110, addr[9:8], rd};
        else     first_b = {addr[6:0], rd};
        second_b = addr[7:0];
    end
endmodule

// File: rtl/i2cseq_buffer.sv
module i2cseq_buffer #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [7:0]       host_wd,
    output logic [7:0]       host_rd,
    input  logic             seq_we,
    input  logic [IDX_W-1:0] seq_idx,
    input  logic [7:0]       seq_wd,
    output logic [7:0]       seq_rd
);
    logic [7:0] mem [DEPTH];

    // Sequencer stores win over host writes in the same cycle
    always_ff @(posedge clk) begin
        if (seq_we)       mem[seq_idx]  <= seq_wd;
        else if (host_we) mem[host_idx] <= host_wd;
    end

    assign host_rd = mem[host_idx];
    assign seq_rd  = mem[seq_idx];
endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm
    import i2cseq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [9:0]       tgt_addr,
    input  logic             ten_bit,
    input  logic             rd_dir,
    input  logic             no_start,
    input  logic [LEN_W-1:0] byte_cnt,
    input  logic             abort,
    input  logic             stat_vld,
    input  logic [7:0]       stat_code,
    input  logic [7:0]       rx_byte,
    // address formatter
    output logic [9:0]       addr_q,
    output logic             ten_q,
    output logic             rd_q,
    input  logic [7:0]       addr_b1,
    input  logic [7:0]       addr_b2,
    // buffer
    output logic             seq_we,
    output logic [IDX_W-1:0] seq_idx,
    output logic [7:0]       seq_wd,
    input  logic [7:0]       seq_rd,
    // master register writes
    output logic             data_we,
    output logic [7:0]       data_wd,
    output logic             ctrl_we,
    output logic [7:0]       ctrl_wd,
    output logic             done,
    output logic [1:0]       result
);
    sq_state_e        state_q, nxt_state;
    logic [LEN_W-1:0] posn_q, nxt_posn;
    logic [LEN_W-1:0] left_q, nxt_left;
    logic             abort_q, nxt_abort;
    logic             ack_q, nxt_ack;
    sq_result_e       res_q, nxt_res;
    logic [9:0]       nxt_addr;
    logic             nxt_ten, nxt_rd;

    logic             o_dwe, o_cwe, o_done;
    logic [7:0]       o_dwd, o_cwd;

    logic             eff_abort;
    logic             is_start, is_addr2, is_wr_next, is_rd_begin;
    logic             is_rd_data, is_rd_last, is_nodev;
    logic             nack_now;

    assign eff_abort = abort_q | abort;

    // status classification
    always_comb begin
        is_start    = (stat_code == ST_START) || (stat_code == ST_RESTART);
        is_addr2    = ten_q && ((stat_code == ST_WA_ACK) || (stat_code == ST_RA_ACK));
        is_wr_next  = (stat_code == ST_WD_ACK) || (stat_code == ST_WA2_ACK) ||
                      ((stat_code == ST_WA_ACK) && !ten_q);
        is_rd_begin = (stat_code == ST_RA2_ACK) || ((stat_code == ST_RA_ACK) && !ten_q);
        is_rd_data  = (stat_code == ST_RD_ACK);
        is_rd_last  = (stat_code == ST_RD_NAK);
        is_nodev    = (stat_code == ST_WA_NAK) || (stat_code == ST_WD_NAK) ||
                      (stat_code == ST_RA_NAK);
    end

    assign seq_idx = (state_q == SQ_IDLE) ? '0 : posn_q[IDX_W-1:0];
    assign seq_wd  = rx_byte;

    // next-state and action decision
    always_comb begin
        nxt_state = state_q;
        nxt_posn  = posn_q;
        nxt_left  = left_q;
        nxt_abort = abort_q;
        nxt_ack   = ack_q;
        nxt_res   = res_q;
        nxt_addr  = addr_q;
        nxt_ten   = ten_q;
        nxt_rd    = rd_q;
        o_dwe     = 1'b0;
        o_dwd     = 8'h00;
        o_cwe     = 1'b0;
        o_cwd     = 8'h00;
        o_done    = 1'b0;
        seq_we    = 1'b0;
        nack_now  = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                nxt_abort = 1'b0;
                if (stat_vld) begin
                    // stray status: release the bus, stay idle
                    o_cwe = 1'b1;
                    o_cwd = ctl_byte(1'b0, 1'b0, 1'b1, ack_q);
                end else if (go) begin
                    nxt_addr = tgt_addr;
                    nxt_ten  = ten_bit;
                    nxt_rd   = rd_dir;
                    nxt_posn = '0;
                    nxt_left = byte_cnt;
                    nxt_ack  = 1'b1;
                    nxt_res  = RES_OK;
                    if (!no_start) begin
                        o_cwe     = 1'b1;
                        o_cwd     = ctl_byte(1'b1, 1'b1, 1'b0, 1'b1);
                        nxt_state = SQ_WAIT_START;
                    end else if (rd_dir) begin
                        nxt_ack   = (byte_cnt != LEN_W'(1));
                        o_cwe     = 1'b1;
                        o_cwd     = ctl_byte(1'b1, 1'b0, 1'b0, nxt_ack);
                        nxt_state = SQ_WAIT_RXDATA;
                    end else if (byte_cnt == '0) begin
                        o_cwe  = 1'b1;
                        o_cwd  = ctl_byte(1'b0, 1'b0, 1'b1, 1'b1);
                        o_done = 1'b1;
                    end else begin
                        o_dwe     = 1'b1;
                        o_dwd     = seq_rd;
                        o_cwe     = 1'b1;
                        o_cwd     = ctl_byte(1'b1, 1'b0, 1'b0, 1'b1);
                        nxt_posn  = LEN_W'(1);
                        nxt_left  = byte_cnt - 1'b1;
                        nxt_state = SQ_WAIT_TXACK;
                    end
                end
            end
            SQ_WAIT_START, SQ_WAIT_ADDR1, SQ_WAIT_ADDR2,
            SQ_WAIT_TXACK, SQ_WAIT_RXDATA: begin
                nxt_abort = eff_abort;
                if (stat_vld) begin
                    if (is_start) begin
                        o_dwe     = 1'b1;
                        o_dwd     = addr_b1;
                        o_cwe     = 1'b1;
                        o_cwd     = ctl_byte(1'b1, 1'b0, 1'b0, ack_q);
                        nxt_state = SQ_WAIT_ADDR1;
                    end else if (is_addr2) begin
                        o_dwe     = 1'b1;
                        o_dwd     = addr_b2;
                        o_cwe     = 1'b1;
                        o_cwd     = ctl_byte(1'b1, 1'b0, 1'b0, ack_q);
                        nxt_state = SQ_WAIT_ADDR2;
                    end else if (is_wr_next) begin
                        if ((left_q == '0) || (eff_abort && (posn_q != '0))) begin
                            o_cwe     = 1'b1;
                            o_cwd     = ctl_byte(1'b0, 1'b0, 1'b1, ack_q);
                            o_done    = 1'b1;
                            nxt_res   = (left_q != '0) ? RES_ABORT : RES_OK;
                            nxt_state = SQ_IDLE;
                        end else begin
                            o_dwe     = 1'b1;
                            o_dwd     = seq_rd;
                            o_cwe     = 1'b1;
                            o_cwd     = ctl_byte(1'b1, 1'b0, 1'b0, ack_q);
                            nxt_posn  = posn_q + 1'b1;
                            nxt_left  = left_q - 1'b1;
                            nxt_state = SQ_WAIT_TXACK;
                        end
                    end else if (is_rd_begin) begin
                        if (left_q == '0) begin
                            o_cwe     = 1'b1;
                            o_cwd     = ctl_byte(1'b0, 1'b0, 1'b1, ack_q);
                            o_done    = 1'b1;
                            nxt_res   = RES_OK;
                            nxt_state = SQ_IDLE;
                        end else begin
                            nack_now  = (left_q == LEN_W'(1)) || eff_abort;
                            nxt_ack   = ack_q & ~nack_now;
                            o_cwe     = 1'b1;
                            o_cwd     = ctl_byte(1'b1, 1'b0, 1'b0, nxt_ack);
                            nxt_state = SQ_WAIT_RXDATA;
                        end
                    end else if (is_rd_data) begin
                        seq_we    = 1'b1;
                        nxt_posn  = posn_q + 1'b1;
                        nxt_left  = (left_q == '0) ? '0 : left_q - 1'b1;
                        nack_now  = (nxt_left == LEN_W'(1)) || eff_abort;
                        nxt_ack   = ack_q & ~nack_now;
                        o_cwe     = 1'b1;
                        o_cwd     = ctl_byte(1'b1, 1'b0, 1'b0, nxt_ack);
                        nxt_state = SQ_WAIT_RXDATA;
                    end else if (is_rd_last) begin
                        seq_we    = 1'b1;
                        nxt_posn  = posn_q + 1'b1;
                        nxt_left  = (left_q == '0) ? '0 : left_q - 1'b1;
                        o_cwe     = 1'b1;
                        o_cwd     = ctl_byte(1'b0, 1'b0, 1'b1, ack_q);
                        o_done    = 1'b1;
                        nxt_res   = (eff_abort && (left_q > LEN_W'(1))) ? RES_ABORT : RES_OK;
                        nxt_state = SQ_IDLE;
                    end else begin
                        o_cwe     = 1'b1;
                        o_cwd     = ctl_byte(1'b0, 1'b0, 1'b1, ack_q);
                        o_done    = 1'b1;
                        nxt_res   = is_nodev ? RES_NODEV : RES_CTLERR;
                        nxt_state = SQ_IDLE;
                    end
                end
            end
            default: nxt_state = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            posn_q  <= '0;
            left_q  <= '0;
            abort_q <= 1'b0;
            ack_q   <= 1'b0;
            res_q   <= RES_OK;
            addr_q  <= '0;
            ten_q   <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            state_q <= nxt_state;
            posn_q  <= nxt_posn;
            left_q  <= nxt_left;
            abort_q <= nxt_abort;
            ack_q   <= nxt_ack;
            res_q   <= nxt_res;
            addr_q  <= nxt_addr;
            ten_q   <= nxt_ten;
            rd_q    <= nxt_rd;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_we <= 1'b0;
            data_wd <= 8'h00;
            ctrl_we <= 1'b0;
            ctrl_wd <= 8'h00;
            done    <= 1'b0;
        end else begin
            data_we <= o_dwe;
            data_wd <= o_dwd;
            ctrl_we <= o_cwe;
            ctrl_wd <= o_cwd;
            done    <= o_done;
        end
    end

    assign result = res_q;

    assert_start_after_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wd[CB_START]) |-> ($past(go) && ($past(state_q) == SQ_IDLE)));

    assert_data_with_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |-> ctrl_we);

    assert_left_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != SQ_IDLE) && ($past(state_q) != SQ_IDLE) && ($past(left_q) == '0))
        |-> (left_q == '0));

    assert_done_in_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == SQ_IDLE));

    assert_idle_entry_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SQ_IDLE) && ($past(state_q) != SQ_IDLE)) |-> done);

    assert_stop_goes_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wd[CB_STOP]) |-> (state_q == SQ_IDLE));

    assert_stop_no_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctrl_we && ctrl_wd[CB_STOP] && !ctrl_wd[CB_IE] && !ctrl_wd[CB_START]));

    assert_ack_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != SQ_IDLE) && ($past(state_q) != SQ_IDLE) && !$past(ack_q)) |-> !ack_q);

endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer #(
    parameter  int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [9:0]       tgt_addr,
    input  logic             ten_bit,
    input  logic             rd_dir,
    input  logic             no_start,
    input  logic [LEN_W-1:0] byte_cnt,
    input  logic             abort,
    input  logic             buf_we,
    input  logic [IDX_W-1:0] buf_idx,
    input  logic [7:0]       buf_wdata,
    output logic [7:0]       buf_rdata,
    input  logic             stat_vld,
    input  logic [7:0]       stat_code,
    input  logic [7:0]       rx_byte,
    output logic             data_we,
    output logic [7:0]       data_wd,
    output logic             ctrl_we,
    output logic [7:0]       ctrl_wd,
    output logic             done,
    output logic [1:0]       result
);
    logic [9:0]       addr_q;
    logic             ten_q, rd_q;
    logic [7:0]       addr_b1, addr_b2;
    logic             seq_we;
    logic [IDX_W-1:0] seq_idx;
    logic [7:0]       seq_wd, seq_rd;

    i2cseq_addr_fmt u_addr (
        .addr     (addr_q),
        .ten      (ten_q),
        .rd       (rd_q),
        .first_b  (addr_b1),
        .second_b (addr_b2)
    );

    i2cseq_buffer #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
        .clk      (clk),
        .host_we  (buf_we),
        .host_idx (buf_idx),
        .host_wd  (buf_wdata),
        .host_rd  (buf_rdata),
        .seq_we   (seq_we),
        .seq_idx  (seq_idx),
        .seq_wd   (seq_wd),
        .seq_rd   (seq_rd)
    );

    i2cseq_fsm #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .tgt_addr  (tgt_addr),
        .ten_bit   (ten_bit),
        .rd_dir    (rd_dir),
        .no_start  (no_start),
        .byte_cnt  (byte_cnt),
        .abort     (abort),
        .stat_vld  (stat_vld),
        .stat_code (stat_code),
        .rx_byte   (rx_byte),
        .addr_q    (addr_q),
        .ten_q     (ten_q),
        .rd_q      (rd_q),
        .addr_b1   (addr_b1),
        .addr_b2   (addr_b2),
        .seq_we    (seq_we),
        .seq_idx   (seq_idx),
        .seq_wd    (seq_wd),
        .seq_rd    (seq_rd),
        .data_we   (data_we),
        .data_wd   (data_wd),
        .ctrl_we   (ctrl_we),
        .ctrl_wd   (ctrl_wd),
        .done      (done),
        .result    (result)
    );
endmodule

// File: tb/sim_i2c_msg_sequencer.sv
module sim_i2c_msg_sequencer;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;
    localparam int LEN_W = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n, go, ten_bit, rd_dir, no_start, abort, buf_we, stat_vld;
    logic [9:0]       tgt_addr;
    logic [LEN_W-1:0] byte_cnt;
    logic [IDX_W-1:0] buf_idx;
    logic [7:0]       buf_wdata, buf_rdata, stat_code, rx_byte;
    logic             data_we, ctrl_we, done;
    logic [7:0]       data_wd, ctrl_wd;
    logic [1:0]       result;

    i2c_msg_sequencer #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .tgt_addr(tgt_addr), .ten_bit(ten_bit),
        .rd_dir(rd_dir), .no_start(no_start), .byte_cnt(byte_cnt), .abort(abort),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .stat_vld(stat_vld), .stat_code(stat_code), .rx_byte(rx_byte),
        .data_we(data_we), .data_wd(data_wd), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .done(done), .result(result)
    );

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] txpat(input int i, input int s);
        return 8'((s * 37 + i * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] rxpat(input int i, input int s);
        return 8'((s * 53 + i * 29 + 17) & 255);
    endfunction

    task automatic fill(input int n, input int s);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_idx = IDX_W'(i); buf_wdata = txpat(i, s);
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic start_msg(input logic [9:0] a, input logic t, input logic r,
                             input logic ns, input int n);
        @(negedge clk);
        go = 1'b1; tgt_addr = a; ten_bit = t; rd_dir = r; no_start = ns;
        byte_cnt = LEN_W'(n);
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic post(input logic [7:0] st, input logic [7:0] d);
        @(negedge clk);
        stat_vld = 1'b1; stat_code = st; rx_byte = d;
        @(negedge clk);
        stat_vld = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
    endtask

    task automatic chk_stop(input string req, input int res);
        chk(req, done, 1);
        chk(req, ctrl_we, 1);
        chk(req, ctrl_wd & 8'hF0, 8'h50);
        chk(req, result, res);
    endtask

    task automatic chk_buf(input string req, input int n, input int s);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            buf_idx = IDX_W'(i);
            #1;
            chk(req, buf_rdata, rxpat(i, s));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [9:0] a;
        logic [7:0] nxt;
        int         s;
        int         e1;
        rst_n = 1'b0; go = 1'b0; ten_bit = 1'b0; rd_dir = 1'b0; no_start = 1'b0;
        abort = 1'b0; buf_we = 1'b0; stat_vld = 1'b0; tgt_addr = '0; byte_cnt = '0;
        buf_idx = '0; buf_wdata = '0; stat_code = '0; rx_byte = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset done", done, 0);
        chk("R8 reset ctrl_we", ctrl_we, 0);
        chk("R8 reset data_we", data_we, 0);

        // R12: stray status in idle
        post(8'h08, 8'h00);
        chk("R12", ctrl_we, 1);
        chk("R12", ctrl_wd & 8'hF0, 8'h50);
        chk("R12", done, 0);
        chk("R12", data_we, 0);

        // Sweep: address width x direction x byte count
        for (int t = 0; t < 2; t++) begin
            for (int r = 0; r < 2; r++) begin
                for (int n = 0; n <= DEPTH; n++) begin
                    s = t * 20 + r * 10 + n;
                    if (t == 1) a = 10'((677 + n * 97 + r * 3) & 1023);
                    else        a = 10'((85 + n * 13) & 127);
                    if (t == 1) e1 = 240 + ((int'(a) >> 8) & 3) * 2 + r;
                    else        e1 = (int'(a) & 127) * 2 + r;
                    if (r == 0) fill(n, s);
                    start_msg(a, t[0], r[0], 1'b0, n);
                    chk("R3", ctrl_we, 1);
                    chk("R3", ctrl_wd, 8'hE4);
                    chk("R3", data_we, 0);
                    post((t == 1 && r == 1) ? 8'h10 : 8'h08, 8'h00);
                    chk(t == 1 ? "R2 first" : "R1", data_wd, e1);
                    chk("R1", data_we, 1);
                    chk("R1", ctrl_wd, 8'hC4);
                    if (t == 1) begin
                        post(r == 1 ? 8'h40 : 8'h18, 8'h00);
                        chk("R2 second", data_we, 1);
                        chk("R2 second", data_wd, int'(a) & 255);
                        nxt = (r == 1) ? 8'hE0 : 8'hD0;
                    end else begin
                        nxt = (r == 1) ? 8'h40 : 8'h18;
                    end
                    if (r == 0) begin
                        for (int i = 0; i < n; i++) begin
                            post(i == 0 ? nxt : 8'h28, 8'h00);
                            chk("R4", data_we, 1);
                            chk("R4", data_wd, txpat(i, s));
                            chk("R4", ctrl_wd, 8'hC4);
                            chk("R4", done, 0);
                        end
                        post(n == 0 ? nxt : 8'h28, 8'h00);
                        chk_stop(n == 0 ? "R7" : "R4", 0);
                        chk("R4", data_we, 0);
                    end else begin
                        post(nxt, 8'h00);
                        if (n == 0) begin
                            chk_stop("R7", 0);
                        end else begin
                            chk("R5", ctrl_wd, (n == 1) ? 8'hC0 : 8'hC4);
                            chk("R5", data_we, 0);
                            for (int i = 0; i < n - 1; i++) begin
                                post(8'h50, rxpat(i, s));
                                chk("R5", ctrl_wd, ((n - 1 - i) > 1) ? 8'hC4 : 8'hC0);
                                chk("R5", done, 0);
                            end
                            post(8'h58, rxpat(n - 1, s));
                            chk_stop("R6", 0);
                            chk("R6", ctrl_wd, 8'h50);
                            chk_buf("R5 R6 stored", n, s);
                        end
                    end
                end
            end
        end

        // R3: go while busy is ignored
        fill(1, 90);
        start_msg(10'h012, 1'b0, 1'b0, 1'b0, 1);
        start_msg(10'h3FF, 1'b1, 1'b1, 1'b0, 3);
        chk("R3 busy go", ctrl_we, 0);
        chk("R3 busy go", data_we, 0);
        post(8'h08, 8'h00);
        chk("R3 busy go", data_wd, 8'h24);
        post(8'h18, 8'h00);
        chk("R3 busy go", data_wd, txpat(0, 90));
        post(8'h28, 8'h00);
        chk_stop("R3 busy go", 0);

        // R8: no-device statuses, one-cycle done
        start_msg(10'h050, 1'b0, 1'b0, 1'b0, 2);
        post(8'h08, 8'h00);
        post(8'h20, 8'h00);
        chk_stop("R8 0x20", 1);
        @(negedge clk);
        chk("R8 pulse", done, 0);
        fill(2, 91);
        start_msg(10'h051, 1'b0, 1'b0, 1'b0, 2);
        post(8'h08, 8'h00);
        post(8'h18, 8'h00);
        post(8'h30, 8'h00);
        chk_stop("R8 0x30", 1);
        start_msg(10'h052, 1'b0, 1'b1, 1'b0, 2);
        post(8'h08, 8'h00);
        post(8'h48, 8'h00);
        chk_stop("R8 0x48", 1);

        // R9: unexpected statuses
        start_msg(10'h053, 1'b0, 1'b0, 1'b0, 2);
        post(8'h08, 8'h00);
        post(8'h38, 8'h00);
        chk_stop("R9 0x38", 2);
        start_msg(10'h054, 1'b0, 1'b0, 1'b0, 2);
        post(8'h08, 8'h00);
        post(8'h18, 8'h00);
        post(8'hF8, 8'h00);
        chk_stop("R9 0xF8", 2);
        start_msg(10'h055, 1'b0, 1'b1, 1'b0, 2);
        post(8'h00, 8'h00);
        chk_stop("R9 0x00", 2);

        // R10: abort after first write byte
        fill(4, 92);
        start_msg(10'h056, 1'b0, 1'b0, 1'b0, 4);
        post(8'h08, 8'h00);
        post(8'h18, 8'h00);
        chk("R10", data_wd, txpat(0, 92));
        pulse_abort();
        post(8'h28, 8'h00);
        chk_stop("R10 write", 3);
        chk("R10 write", data_we, 0);
        // abort before any byte: first byte still goes out
        start_msg(10'h057, 1'b0, 1'b0, 1'b0, 4);
        pulse_abort();
        post(8'h08, 8'h00);
        post(8'h18, 8'h00);
        chk("R10 first byte", data_we, 1);
        chk("R10 first byte", data_wd, txpat(0, 92));
        post(8'h28, 8'h00);
        chk_stop("R10 first byte", 3);
        // abort during read
        start_msg(10'h058, 1'b0, 1'b1, 1'b0, 4);
        post(8'h08, 8'h00);
        post(8'h40, 8'h00);
        chk("R10 read", ctrl_wd, 8'hC4);
        pulse_abort();
        post(8'h50, rxpat(0, 93));
        chk("R10 read nack", ctrl_wd, 8'hC0);
        post(8'h58, rxpat(1, 93));
        chk_stop("R10 read", 3);
        chk_buf("R10 read stored", 2, 93);
        // abort in idle is ignored
        pulse_abort();
        fill(1, 94);
        start_msg(10'h059, 1'b0, 1'b0, 1'b0, 1);
        post(8'h08, 8'h00);
        post(8'h18, 8'h00);
        chk("R10 idle abort", data_wd, txpat(0, 94));
        post(8'h28, 8'h00);
        chk_stop("R10 idle abort", 0);

        // R11: no-start option
        fill(2, 95);
        start_msg(10'h05A, 1'b0, 1'b0, 1'b1, 2);
        chk("R11 write", data_we, 1);
        chk("R11 write", data_wd, txpat(0, 95));
        chk("R11 write", ctrl_wd, 8'hC4);
        post(8'h28, 8'h00);
        chk("R11 write", data_wd, txpat(1, 95));
        post(8'h28, 8'h00);
        chk_stop("R11 write", 0);
        start_msg(10'h05B, 1'b0, 1'b1, 1'b1, 2);
        chk("R11 read", data_we, 0);
        chk("R11 read", ctrl_wd, 8'hC4);
        post(8'h50, rxpat(0, 96));
        chk("R11 read", ctrl_wd, 8'hC0);
        post(8'h58, rxpat(1, 96));
        chk_stop("R11 read", 0);
        chk_buf("R11 read stored", 2, 96);
        start_msg(10'h05C, 1'b0, 1'b1, 1'b1, 1);
        chk("R11 read one", ctrl_wd, 8'hC0);
        post(8'h58, rxpat(0, 97));
        chk_stop("R11 read one", 0);
        start_msg(10'h05D, 1'b0, 1'b0, 1'b1, 0);
        chk_stop("R11 empty write", 0);
        chk("R11 empty write", data_we, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule